// File: doc/BRIEF.md
# Dual Instruction Prefetch Buffer Controller

This block sits between an instruction fetch stage and an instruction cache and manages a pair of line buffers. For each fetch it rounds the PC down to a line boundary. The line size is 8 or 16 bytes and is picked by a mode input. The buffer that already holds that line becomes the current buffer. If neither buffer holds it, buffer 0 is claimed as the current buffer. On a mismatch the current buffer is retargeted, and a tagged load request goes to the cache. At the same time the other buffer is checked against the next sequential line. If it does not hold that line, it is reloaded with its own tagged request. Over time the current and lookahead roles alternate between the two buffers.

Request tags come from a running counter. The cache answers each request with a response that carries the same tag. A response whose tag matches what a buffer is waiting for marks that buffer idle. When cycle accounting is on, a fetch is held until the current buffer is idle, and every cycle of waiting adds to a stall counter. A branch penalty may be posted beforehand. It is then paid once, as extra stall cycles, on the next fetch that starts an instruction packet. When the cache is disabled and accounting is off, fetches pass straight through untouched.

Top module: `dual_prefetch_ctrl`

## Requirements
- R1: The line address is the fetch PC with its low 3 bits cleared when `wide_mode`=0 (8-byte lines) or its low 4 bits cleared when `wide_mode`=1 (16-byte lines); every request address is such a line address.
- R2: At a lookup, a buffer whose valid address equals the line address becomes current, with buffer 0 winning if both match; if neither matches, buffer 0 becomes current. `cur_buf` shows the index chosen at the latest lookup, from the cycle after it.
- R3: If the current buffer does not hold the line address, `req_valid[cur]` is 1 in the lookup cycle, with `req_addr[cur]` equal to the line address.
- R4: In a lookup cycle the other buffer, index (cur+1) mod 2, is checked against line address + line size; if it does not hold it, `req_valid` for that buffer is 1 with that address, and after the lookup it holds that address.
- R5: Tags start at 0x80000000 after reset and step by one per request issued; when both buffers issue in the same cycle, the current buffer takes the lower tag.
- R6: With `count_en`=1, `fetch_done` stays 0 while the current buffer's request is outstanding, and `stall_cycles` rises by one for each such cycle; `fetch_done` is 1 in the first wait cycle that finds the buffer idle.
- R7: A penalty loaded with `pen_load` is paid as that many stall cycles, each added to `stall_cycles`, before the wait phase of the next accounted fetch with `fetch_first`=1; it is then cleared, and fetches with `fetch_first`=0 leave it pending.
- R8: With `icache_en`=0 and `count_en`=0, a fetch completes in the same cycle with no request, and the buffer contents stay unchanged.
- R9: With `icache_en`=1 and `count_en`=0, requests are still issued but `fetch_done` is 1 in the lookup cycle and no stall is counted.
- R10: A response whose tag matches no outstanding buffer tag changes nothing.
- R11: After reset both buffers hold no address (the first lookup misses in both), `stall_cycles` is 0, `cur_buf` is 0 and no request is active.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| icache_en | input | 1 | Instruction cache enabled |
| count_en | input | 1 | Cycle accounting enabled (fetches stall) |
| wide_mode | input | 1 | 0: 8-byte lines, 1: 16-byte lines |
| fetch_valid | input | 1 | Fetch request, held until `fetch_done` |
| fetch_pc | input | AW | Fetch address |
| fetch_first | input | 1 | Fetch is the first instruction of a packet |
| pen_load | input | 1 | Load a pending branch penalty |
| pen_cycles | input | PW | Penalty length in cycles |
| rsp_valid | input | 1 | Cache response strobe |
| rsp_tag | input | TW | Tag of the completed request |
| fetch_done | output | 1 | Fetch completes this cycle |
| cur_buf | output | 1 | Index of the current buffer |
| req_valid | output | 2 | Load request strobe, one bit per buffer |
| req_addr | output | 2 x AW | Request line address per buffer |
| req_tag | output | 2 x TW | Request tag per buffer |
| stall_cycles | output | SW | Accumulated stall cycles |

## Verification
The assertions assume several things about the environment. `fetch_valid`, `fetch_pc` and `fetch_first` stay steady until `fetch_done`, and the mode inputs change only between fetches. The cache returns each issued tag at most once, and `pen_load` never coincides with a lookup. The stimulus follows all of these rules: it advances to a new fetch only after a completed one, changes modes and posts penalties in gaps with `fetch_valid` low, and uses a responder that pops each issued tag from a FIFO exactly once. It also injects stray responses with tags below 0x80000000, which are never issued.

// File: rtl/pf_pkg.sv
package pf_pkg;
  typedef enum logic [1:0] {
    PF_IDLE    = 2'd0,
    PF_PENALTY = 2'd1,
    PF_WAIT    = 2'd2
  } pf_state_e;

  localparam int unsigned PF_NBUF = 2;
endpackage

// File: rtl/pf_buffer.sv
module pf_buffer #(
  parameter int unsigned AW = 32,
  parameter int unsigned TW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load_en,
  input  logic [AW-1:0] load_addr,
  input  logic [TW-1:0] load_tag,
  input  logic          rsp_valid,
  input  logic [TW-1:0] rsp_tag,
  output logic          valid_o,
  output logic [AW-1:0] addr_o,
  output logic [TW-1:0] tag_o,
  output logic          busy_o
);
  logic          val_q, val_d;
  logic          busy_q, busy_d;
  logic [AW-1:0] addr_q;
  logic [TW-1:0] tag_q;
  logic          rsp_hit;

  always_comb begin
    rsp_hit = rsp_valid && busy_q && (rsp_tag == tag_q);
    val_d   = val_q | load_en;
    if (load_en)      busy_d = 1'b1;
    else if (rsp_hit) busy_d = 1'b0;
    else              busy_d = busy_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      val_q  <= 1'b0;
      busy_q <= 1'b0;
    end else begin
      val_q  <= val_d;
      busy_q <= busy_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_q <= '0;
      tag_q  <= '0;
    end else if (load_en) begin
      addr_q <= load_addr;
      tag_q  <= load_tag;
    end
  end

  assign valid_o = val_q;
  assign addr_o  = addr_q;
  assign tag_o   = tag_q;
  assign busy_o  = busy_q;

  // R10
  busy_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_q && !load_en && !(rsp_valid && rsp_tag == tag_q)) |=> busy_q);

  // R3
  load_capture_chk: assert property (@(posedge clk) disable iff (!rst_n)
    load_en |=> (busy_q && val_q && addr_q == $past(load_addr)));
endmodule

// File: rtl/pf_tag_gen.sv
module pf_tag_gen #(
  parameter int unsigned TW       = 32,
  parameter logic [TW-1:0] TAG_INIT = 32'h8000_0000
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [1:0]    issue_cnt,
  output logic [TW-1:0] tag_base
);
  logic [TW-1:0] ctr_q, ctr_d;
  logic          ctr_en;

  always_comb begin
    ctr_en = (issue_cnt != 2'd0);
    ctr_d  = ctr_q + TW'(issue_cnt);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      ctr_q <= TAG_INIT;
    else if (ctr_en) ctr_q <= ctr_d;
  end

  assign tag_base = ctr_q;

  // R5
  tag_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (issue_cnt == 2'd0) |=> $stable(ctr_q));
endmodule

// File: rtl/pf_stall_fsm.sv
module pf_stall_fsm
  import pf_pkg::*;
#(
  parameter int unsigned PW = 4,
  parameter int unsigned SW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          fetch_valid,
  input  logic          active,
  input  logic          count_en,
  input  logic          fetch_first,
  input  logic          busy_cur,
  input  logic          pen_load,
  input  logic [PW-1:0] pen_cycles,
  output logic          lookup,
  output logic          fetch_done,
  output logic [SW-1:0] stall_cycles
);
  pf_state_e     st_q, st_d;
  logic [PW-1:0] cnt_q, cnt_d;
  logic [PW-1:0] pend_q, pend_d;
  logic [SW-1:0] stall_q, stall_d;
  logic          consume;
  logic          stall_en;

  always_comb begin
    lookup   = (st_q == PF_IDLE) && fetch_valid && active;
    consume  = lookup && count_en && fetch_first && (pend_q != '0);
    st_d     = st_q;
    cnt_d    = cnt_q;
    stall_en = 1'b0;
    unique case (st_q)
      PF_IDLE: begin
        if (lookup && count_en) begin
          st_d  = consume ? PF_PENALTY : PF_WAIT;
          cnt_d = pend_q;
        end
      end
      PF_PENALTY: begin
        stall_en = 1'b1;
        if (cnt_q <= PW'(1)) st_d = PF_WAIT;
        else                 cnt_d = cnt_q - PW'(1);
      end
      PF_WAIT: begin
        if (busy_cur) stall_en = 1'b1;
        else          st_d = PF_IDLE;
      end
      default: st_d = PF_IDLE;
    endcase
    stall_d = stall_q + SW'(1);
    if (pen_load)     pend_d = pen_cycles;
    else if (consume) pend_d = '0;
    else              pend_d = pend_q;
    fetch_done = ((st_q == PF_IDLE) && fetch_valid && !(active && count_en))
              || ((st_q == PF_WAIT) && !busy_cur);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= PF_IDLE;
      cnt_q  <= '0;
      pend_q <= '0;
    end else begin
      st_q   <= st_d;
      cnt_q  <= cnt_d;
      pend_q <= pend_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        stall_q <= '0;
    else if (stall_en) stall_q <= stall_d;
  end

  assign stall_cycles = stall_q;

  // R7
  pen_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (consume && !pen_load) |=> (pend_q == '0));

  // R6
  stall_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == PF_WAIT && busy_cur) |=> (stall_q == $past(stall_q) + SW'(1)));

  // R9
  no_stall_unaccounted_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == PF_IDLE && !count_en) |=> $stable(stall_q));
endmodule

// File: rtl/dual_prefetch_ctrl.sv
module dual_prefetch_ctrl
  import pf_pkg::*;
#(
  parameter int unsigned   AW         = 32,
  parameter int unsigned   TW         = 32,
  parameter int unsigned   PW         = 4,
  parameter int unsigned   SW         = 32,
  parameter int unsigned   SMALL_LOG2 = 3,
  parameter int unsigned   WIDE_LOG2  = 4,
  parameter logic [TW-1:0] TAG_INIT   = 32'h8000_0000
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   icache_en,
  input  logic                   count_en,
  input  logic                   wide_mode,
  input  logic                   fetch_valid,
  input  logic [AW-1:0]          fetch_pc,
  input  logic                   fetch_first,
  input  logic                   pen_load,
  input  logic [PW-1:0]          pen_cycles,
  input  logic                   rsp_valid,
  input  logic [TW-1:0]          rsp_tag,
  output logic                   fetch_done,
  output logic                   cur_buf,
  output logic [1:0]             req_valid,
  output logic [1:0][AW-1:0]     req_addr,
  output logic [1:0][TW-1:0]     req_tag,
  output logic [SW-1:0]          stall_cycles
);
  localparam logic [AW-1:0] SMALL_BYTES = AW'(1) << SMALL_LOG2;
  localparam logic [AW-1:0] WIDE_BYTES  = AW'(1) << WIDE_LOG2;
  localparam logic [AW-1:0] SMALL_MASK  = {AW{1'b1}} << SMALL_LOG2;
  localparam logic [AW-1:0] WIDE_MASK   = {AW{1'b1}} << WIDE_LOG2;

  logic [1:0] rst_sync_q;
  logic       rst_int_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_int_n = rst_sync_q[1];

  logic [PF_NBUF-1:0]         buf_val, buf_busy, hit, load_en;
  logic [PF_NBUF-1:0][AW-1:0] buf_addr, load_addr;
  logic [PF_NBUF-1:0][TW-1:0] buf_tag, load_tag;
  logic [AW-1:0] line_bytes, line_addr, next_line;
  logic [TW-1:0] tag_base;
  logic          cur_sel, oth_sel, pf_hit, iss_cur, iss_oth;
  logic          lookup, active, cur_q;

  always_comb begin
    line_bytes = wide_mode ? WIDE_BYTES : SMALL_BYTES;
    line_addr  = fetch_pc & (wide_mode ? WIDE_MASK : SMALL_MASK);
    next_line  = line_addr + line_bytes;
    active     = icache_en | count_en;
  end

  for (genvar b = 0; b < PF_NBUF; b++) begin : g_buf
    localparam logic BIDX = 1'(b);
    logic is_cur;

    assign hit[b]       = buf_val[b] && (buf_addr[b] == line_addr);
    assign is_cur       = (cur_sel == BIDX);
    assign load_en[b]   = is_cur ? iss_cur : iss_oth;
    assign load_addr[b] = is_cur ? line_addr : next_line;
    assign load_tag[b]  = is_cur ? tag_base : (tag_base + TW'(iss_cur));

    pf_buffer #(.AW(AW), .TW(TW)) u_buf (
      .clk       (clk),
      .rst_n     (rst_int_n),
      .load_en   (load_en[b]),
      .load_addr (load_addr[b]),
      .load_tag  (load_tag[b]),
      .rsp_valid (rsp_valid),
      .rsp_tag   (rsp_tag),
      .valid_o   (buf_val[b]),
      .addr_o    (buf_addr[b]),
      .tag_o     (buf_tag[b]),
      .busy_o    (buf_busy[b])
    );

    // R1
    req_aligned_chk: assert property (@(posedge clk) disable iff (!rst_int_n)
      req_valid[b] |-> (req_addr[b][SMALL_LOG2-1:0] == '0));
  end

  always_comb begin
    cur_sel = hit[0] ? 1'b0 : hit[1];
    oth_sel = ~cur_sel;
    pf_hit  = buf_val[oth_sel] && (buf_addr[oth_sel] == next_line);
    iss_cur = lookup && !hit[cur_sel];
    iss_oth = lookup && !pf_hit;
  end

  pf_tag_gen #(.TW(TW), .TAG_INIT(TAG_INIT)) u_tags (
    .clk       (clk),
    .rst_n     (rst_int_n),
    .issue_cnt ({1'b0, iss_cur} + {1'b0, iss_oth}),
    .tag_base  (tag_base)
  );

  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n)  cur_q <= 1'b0;
    else if (lookup) cur_q <= cur_sel;
  end

  pf_stall_fsm #(.PW(PW), .SW(SW)) u_fsm (
    .clk          (clk),
    .rst_n        (rst_int_n),
    .fetch_valid  (fetch_valid),
    .active       (active),
    .count_en     (count_en),
    .fetch_first  (fetch_first),
    .busy_cur     (buf_busy[cur_q]),
    .pen_load     (pen_load),
    .pen_cycles   (pen_cycles),
    .lookup       (lookup),
    .fetch_done   (fetch_done),
    .stall_cycles (stall_cycles)
  );

  assign cur_buf   = cur_q;
  assign req_valid = load_en;
  assign req_addr  = load_addr;
  assign req_tag   = load_tag;

  // R4
  lookahead_pair_chk: assert property (@(posedge clk) disable iff (!rst_int_n)
    lookup |=> (&buf_val) && (buf_addr[~cur_q] == buf_addr[cur_q] + $past(line_bytes)));

  // R5
  tag_order_chk: assert property (@(posedge clk) disable iff (!rst_int_n)
    (&req_valid) |-> (req_tag[oth_sel] == req_tag[cur_sel] + TW'(1)));

  // R8
  passthrough_chk: assert property (@(posedge clk) disable iff (!rst_int_n)
    (fetch_valid && !icache_en && !count_en) |-> (req_valid == 2'b00));

  // R6
  done_when_idle_chk: assert property (@(posedge clk) disable iff (!rst_int_n)
    (fetch_done && count_en && !lookup) |-> !buf_busy[cur_q]);
endmodule

// File: tb/dual_prefetch_ctrl_tb_top.sv
module dual_prefetch_ctrl_tb_top;
  localparam int AW = 32;
  localparam int TW = 32;
  localparam int PW = 4;
  localparam int SW = 32;
  localparam int LIMIT = 20000;

  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic              rst_n, icache_en, count_en, wide_mode;
  logic              fetch_valid, fetch_first, pen_load, rsp_valid;
  logic [AW-1:0]     fetch_pc;
  logic [PW-1:0]     pen_cycles;
  logic [TW-1:0]     rsp_tag;
  logic              fetch_done, cur_buf;
  logic [1:0]        req_valid;
  logic [1:0][AW-1:0] req_addr;
  logic [1:0][TW-1:0] req_tag;
  logic [SW-1:0]     stall_cycles;

  dual_prefetch_ctrl dut_i (
    .clk(clk), .rst_n(rst_n), .icache_en(icache_en), .count_en(count_en),
    .wide_mode(wide_mode), .fetch_valid(fetch_valid), .fetch_pc(fetch_pc),
    .fetch_first(fetch_first), .pen_load(pen_load), .pen_cycles(pen_cycles),
    .rsp_valid(rsp_valid), .rsp_tag(rsp_tag), .fetch_done(fetch_done),
    .cur_buf(cur_buf), .req_valid(req_valid), .req_addr(req_addr),
    .req_tag(req_tag), .stall_cycles(stall_cycles)
  );

  // drive requests
  logic          d_ice, d_cen, d_wide, d_fv, d_first, d_pl;
  logic [AW-1:0] d_pc;
  logic [PW-1:0] d_pv;

  // reference model state
  logic [AW-1:0] m_addr [2];
  bit            m_val  [2];
  bit            m_busy [2];
  logic [TW-1:0] m_tag  [2];
  logic [TW-1:0] m_ctr;
  int            m_st, m_cnt, m_pend, m_cur;
  logic [SW-1:0] m_stall;

  logic [TW-1:0] rq_tag [$];
  int            rq_due [$];
  int            lat;
  bit            bogus_en;

  int    checks, errors, cyc;
  string ptag;
  bit    last_done;

  task automatic chk(input bit ok, input string req, input logic [63:0] act,
                     input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s [%s] cycle %0d act=%h exp=%h", req, ptag, cyc, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  task automatic tick();
    int            sz, c, o, sn;
    logic [AW-1:0] al, nl;
    bit            act, look, h0, h1, hc, ic, io, e_done, consume, bc;
    logic [1:0]    e_rv;
    logic [AW-1:0] e_addr [2];
    logic [TW-1:0] e_tag  [2];
    @(negedge clk);
    cyc++;
    if (cyc > LIMIT) begin
      errors++;
      $display("FAIL watchdog [%s] act=%0d exp=%0d", ptag, cyc, LIMIT);
      finish_run();
    end
    icache_en = d_ice; count_en = d_cen; wide_mode = d_wide;
    fetch_valid = d_fv; fetch_pc = d_pc; fetch_first = d_first;
    pen_load = d_pl; pen_cycles = d_pv;
    rsp_valid = 1'b0; rsp_tag = '0;
    if (rq_tag.size() > 0 && rq_due[0] <= cyc) begin
      rsp_valid = 1'b1;
      rsp_tag = rq_tag.pop_front();
      void'(rq_due.pop_front());
    end else if (bogus_en && (cyc % 5 == 0)) begin
      rsp_valid = 1'b1;
      rsp_tag = 32'h0000_00a5 + TW'(cyc);
    end
    #1;
    // expected outputs from requirements
    sz   = d_wide ? 16 : 8;
    al   = d_pc & ~(AW'(sz) - 1);
    nl   = al + AW'(sz);
    act  = d_ice | d_cen;
    look = (m_st == 0) && d_fv && act;
    h0   = m_val[0] && (m_addr[0] == al);
    h1   = m_val[1] && (m_addr[1] == al);
    c    = h0 ? 0 : (h1 ? 1 : 0);
    o    = 1 - c;
    hc   = (c == 0) ? h0 : h1;
    ic   = look && !hc;
    io   = look && !(m_val[o] && m_addr[o] == nl);
    e_rv = 2'b00;
    e_rv[c] = ic; e_rv[o] = io;
    e_addr[c] = al; e_addr[o] = nl;
    e_tag[c] = m_ctr; e_tag[o] = m_ctr + TW'(ic);
    e_done = ((m_st == 0) && d_fv && !(act && d_cen)) ||
             ((m_st == 2) && !m_busy[m_cur]);
    // R3: request strobes
    chk(req_valid == e_rv, "R3", 64'(req_valid), 64'(e_rv));
    for (int b = 0; b < 2; b++) begin
      if (e_rv[b]) begin
        // R1 and R4: line and next-line addresses
        chk(req_addr[b] == e_addr[b], "R1", 64'(req_addr[b]), 64'(e_addr[b]));
        // R5: tag values
        chk(req_tag[b] == e_tag[b], "R5", 64'(req_tag[b]), 64'(e_tag[b]));
      end
    end
    // R6: completion timing
    chk(fetch_done == e_done, "R6", 64'(fetch_done), 64'(e_done));
    // R7: stall and penalty accounting
    chk(stall_cycles == m_stall, "R7", 64'(stall_cycles), 64'(m_stall));
    // R2: current buffer
    chk(cur_buf == 1'(m_cur), "R2", 64'(cur_buf), 64'(m_cur));
    // advance the model by one clock
    consume = look && d_cen && d_first && (m_pend > 0);
    bc = m_busy[m_cur];
    if (m_st == 0) begin
      if (look && d_cen) begin
        if (consume) begin m_st = 1; m_cnt = m_pend; end
        else m_st = 2;
      end
    end else if (m_st == 1) begin
      m_stall++;
      if (m_cnt <= 1) m_st = 2; else m_cnt--;
    end else begin
      if (bc) m_stall++; else m_st = 0;
    end
    if (look) m_cur = c;
    if (d_pl) m_pend = int'(d_pv); else if (consume) m_pend = 0;
    for (int b = 0; b < 2; b++) begin
      if (e_rv[b]) begin
        m_addr[b] = e_addr[b]; m_val[b] = 1; m_busy[b] = 1; m_tag[b] = e_tag[b];
      end else if (rsp_valid && m_busy[b] && rsp_tag == m_tag[b]) begin
        m_busy[b] = 0;
      end
    end
    if (ic) begin rq_tag.push_back(e_tag[c]); rq_due.push_back(cyc + lat); end
    if (io) begin rq_tag.push_back(e_tag[o]); rq_due.push_back(cyc + lat); end
    sn = int'(ic) + int'(io);
    m_ctr = m_ctr + TW'(sn);
    last_done = e_done;
  endtask

  task automatic do_fetch(input logic [AW-1:0] pc, input bit first);
    d_fv = 1'b1; d_pc = pc; d_first = first;
    do tick(); while (!last_done);
  endtask

  task automatic gap(input int n);
    d_fv = 1'b0;
    for (int i = 0; i < n; i++) tick();
  endtask

  task automatic post_penalty(input int n);
    d_fv = 1'b0; d_pl = 1'b1; d_pv = PW'(n);
    tick();
    d_pl = 1'b0;
  endtask

  initial begin
    checks = 0; errors = 0; cyc = 0; ptag = "R11"; last_done = 0;
    lat = 3; bogus_en = 0;
    for (int b = 0; b < 2; b++) begin
      m_addr[b] = '0; m_val[b] = 0; m_busy[b] = 0; m_tag[b] = '0;
    end
    m_ctr = 32'h8000_0000; m_st = 0; m_cnt = 0; m_pend = 0; m_cur = 0; m_stall = '0;
    d_ice = 1; d_cen = 1; d_wide = 0; d_fv = 0; d_first = 0; d_pl = 0;
    d_pc = '0; d_pv = '0;
    icache_en = 1; count_en = 1; wide_mode = 0; fetch_valid = 0; fetch_first = 0;
    fetch_pc = '0; pen_load = 0; pen_cycles = '0; rsp_valid = 0; rsp_tag = '0;
    rst_n = 1'b0;
    repeat (4) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    // R11: reset state at the ports
    #1;
    chk(stall_cycles == '0, "R11", 64'(stall_cycles), 64'd0);
    chk(req_valid == 2'b00, "R11", 64'(req_valid), 64'd0);
    chk(cur_buf == 1'b0, "R11", 64'(cur_buf), 64'd0);
    chk(fetch_done == 1'b0, "R11", 64'(fetch_done), 64'd0);
    gap(4);

    // R2 R3 R4: narrow lines, sequential run then a branch and return
    ptag = "R4";
    do_fetch(32'h100, 1);
    do_fetch(32'h104, 0);
    do_fetch(32'h108, 0);
    do_fetch(32'h10c, 0);
    do_fetch(32'h110, 1);
    do_fetch(32'h200, 1);
    do_fetch(32'h118, 1);
    do_fetch(32'h11c, 0);

    // R1: wide lines
    ptag = "R1";
    d_wide = 1; lat = 5;
    gap(2);
    do_fetch(32'h1004, 1);
    do_fetch(32'h100c, 0);
    do_fetch(32'h1010, 0);
    do_fetch(32'h1020, 1);
    do_fetch(32'h1008, 1);

    // R10: stray responses
    ptag = "R10";
    bogus_en = 1; d_wide = 0; lat = 4;
    gap(2);
    do_fetch(32'h300, 1);
    do_fetch(32'h308, 0);
    do_fetch(32'h40c, 1);
    gap(6);

    // R7: one-time branch penalty
    ptag = "R7";
    bogus_en = 0; lat = 2;
    post_penalty(5);
    do_fetch(32'h500, 0);
    do_fetch(32'h504, 1);
    do_fetch(32'h600, 1);
    post_penalty(3);
    do_fetch(32'h608, 1);

    // R8: cache off and no accounting
    ptag = "R8";
    gap(8);
    d_ice = 0; d_cen = 0;
    gap(1);
    do_fetch(32'h900, 1);
    do_fetch(32'h908, 0);
    d_ice = 1; d_cen = 1;
    gap(1);
    do_fetch(32'h608, 1);

    // R9: cache on without accounting
    ptag = "R9";
    d_cen = 0;
    gap(1);
    do_fetch(32'hA00, 1);
    do_fetch(32'hB10, 0);
    do_fetch(32'hA08, 1);
    d_cen = 1;
    gap(12);
    do_fetch(32'hA08, 1);
    gap(3);

    finish_run();
  end
endmodule